// File: doc/BRIEF.md
# Data Breakpoint Range Matcher

This block checks each data access against a set of hardware data breakpoint slots. Every slot's address comes in on its own port. Each slot's access type, byte length and enable bits are decoded from a shared debug control word. The block compares an access (address, byte size, read or write, system-table flag) with every slot. It returns a small result word with three parts: a page-of-interest flag, a hit bit for each slot, and a silent-hit flag. The caller uses this word to decide whether a debug trap is due, or whether the page has to be routed through the slow path on every access.

The access is assumed to stay inside one 4 KiB page. Two vendor behaviours are supported. In strict mode only slots that are both enabled and overlapping are reported. In permissive mode every overlapping slot of a suitable type is reported once any enabled slot overlaps. In permissive mode a descriptor-table (system) access reports only the silent flag. The result is computed combinationally and captured when the access-valid strobe is high. The block does not update any status register itself.

Top module: `dbp_range_match`

## Requirements
- R1: The 2-bit length code of slot i (control bits 18+4i and 19+4i) selects the breakpoint length: 00 gives 1 byte, 01 gives 2, 10 gives 8 and 11 gives 4.
- R2: A read access (acc_write_i=0) is compared only with slots whose type code (control bits 16+4i and 17+4i) is 11.
- R3: A write access is compared with any slot whose type code has bit 0 set (01 or 11). Slots with type 00 or 10 are never compared.
- R4: A compared slot overlaps the access when acc_addr < bp_addr + length and acc_addr + size > bp_addr. No wrap-around is applied.
- R5: A slot is compared only if its address lies in the same 4 KiB page as the access (address bits above bit 11 are equal). An enabled compared slot sets result bit 0 even when it does not overlap. A slot is enabled when either of control bits 2i and 2i+1 is set.
- R6: When resume_i is set, the result is all zero.
- R7: When no slot of a type relevant to the access direction is enabled, the result is all zero.
- R8: Result bits 1..4 and 5 stay zero unless at least one slot is both enabled and overlapping.
- R9: In strict mode (vendor_all_i=0), result bit 1+i is set for each slot i that is enabled and overlapping. Bit 5 is never set.
- R10: In permissive mode (vendor_all_i=1) with a non-system access, result bit 1+i is set for every overlapping compared slot, enabled or not.
- R11: In permissive mode with a system access, bits 1..4 stay zero and bit 5 (silent hit) is set instead.
- R12: The result is captured on the clock edge where acc_valid_i is high. result_valid_o pulses for one cycle after each capture. result_o holds its value between captures and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe; captures the result |
| acc_addr_i | input | 32 | Linear address of the access |
| acc_size_i | input | 4 | Access size in bytes |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_sys_i | input | 1 | Access to a descriptor table |
| resume_i | input | 1 | Resume flag; suppresses all checking |
| vendor_all_i | input | 1 | 0 = strict mode, 1 = permissive mode |
| ctrl_i | input | 32 | Debug control word (enables, types, lengths) |
| bp_addr_i | input | 128 | Four slot addresses, slot i at bits 32i+31..32i |
| result_o | output | 6 | bit0 page of interest, bits1..4 slot hits, bit5 silent hit |
| result_valid_o | output | 1 | One-cycle pulse after a capture |

## Verification
The assertions check the following on every cycle: the strobe-to-valid timing, holding of the result between strobes, that resume yields zero, that the silent flag never appears together with slot hits or in strict mode, and that any hit also raises the page flag. The exact overlap boundaries for each length code, the type filtering by direction, the page comparison and the difference between strict and permissive hit masks can only be shown by the bench scenarios. These compare each captured word with a reference model.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  typedef enum logic [1:0] {
    BT_EXEC = 2'b00,
    BT_WO   = 2'b01,
    BT_IO   = 2'b10,
    BT_RW   = 2'b11
  } bp_type_e;

  // Non-monotonic length code: 00->1, 01->2, 10->8, 11->4
  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   len_bytes = 4'd1;
      2'b01:   len_bytes = 4'd2;
      2'b10:   len_bytes = 4'd8;
      default: len_bytes = 4'd4;
    endcase
  endfunction

  function automatic logic type_relevant(input logic [1:0] typ, input logic is_write);
    if (is_write) type_relevant = typ[0];
    else          type_relevant = (bp_type_e'(typ) == BT_RW);
  endfunction
endpackage

// File: rtl/dbp_slot.sv
module dbp_slot #(
  parameter int AW         = 32,
  parameter int SIZE_W     = 4,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [AW-1:0]     bp_addr_i,
  input  logic [1:0]        typ_i,
  input  logic [1:0]        len_code_i,
  input  logic [1:0]        en_bits_i,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [SIZE_W-1:0] acc_size_i,
  input  logic              acc_write_i,
  output logic              rel_en_o,
  output logic              page_en_o,
  output logic              match_o
);
  import dbp_pkg::*;

  localparam int XW = AW + 1;

  logic          typ_ok, same_page, considered, enabled;
  logic [XW-1:0] acc_lo, acc_hi, bp_lo, bp_hi;

  always_comb begin
    typ_ok     = type_relevant(typ_i, acc_write_i);
    enabled    = |en_bits_i;
    same_page  = (bp_addr_i[AW-1:PAGE_SHIFT] == acc_addr_i[AW-1:PAGE_SHIFT]);
    considered = typ_ok & same_page;
    acc_lo     = {1'b0, acc_addr_i};
    acc_hi     = acc_lo + XW'(acc_size_i);
    bp_lo      = {1'b0, bp_addr_i};
    bp_hi      = bp_lo + XW'(len_bytes(len_code_i));
    rel_en_o   = typ_ok & enabled;
    page_en_o  = considered & enabled;
    match_o    = considered & (acc_lo < bp_hi) & (acc_hi > bp_lo);
  end
endmodule

// File: rtl/dbp_combine.sv
module dbp_combine #(
  parameter int NUM_SLOTS = 4,
  localparam int RES_W    = NUM_SLOTS + 2
) (
  input  logic                 active_i,
  input  logic                 vendor_all_i,
  input  logic                 sys_i,
  input  logic [NUM_SLOTS-1:0] page_en_i,
  input  logic [NUM_SLOTS-1:0] match_i,
  output logic [RES_W-1:0]     result_o
);
  localparam int SIL = NUM_SLOTS + 1;

  logic [NUM_SLOTS-1:0] both;

  always_comb begin
    both     = page_en_i & match_i;
    result_o = '0;
    if (active_i) begin
      result_o[0] = |page_en_i;
      if (|both) begin
        if (!vendor_all_i)  result_o[NUM_SLOTS:1] = both;
        else if (!sys_i)    result_o[NUM_SLOTS:1] = match_i;
        else                result_o[SIL]         = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbp_range_match.sv
module dbp_range_match #(
  parameter int AW         = 32,
  parameter int SIZE_W     = 4,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_SLOTS  = 4,
  localparam int CTRL_W    = 16 + 4 * NUM_SLOTS,
  localparam int RES_W     = NUM_SLOTS + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    acc_valid_i,
  input  logic [AW-1:0]           acc_addr_i,
  input  logic [SIZE_W-1:0]       acc_size_i,
  input  logic                    acc_write_i,
  input  logic                    acc_sys_i,
  input  logic                    resume_i,
  input  logic                    vendor_all_i,
  input  logic [CTRL_W-1:0]       ctrl_i,
  input  logic [NUM_SLOTS*AW-1:0] bp_addr_i,
  output logic [RES_W-1:0]        result_o,
  output logic                    result_valid_o
);
  logic [NUM_SLOTS-1:0] rel_en, page_en, match;
  logic [RES_W-1:0]     res_d;
  logic                 active;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    dbp_slot #(.AW(AW), .SIZE_W(SIZE_W), .PAGE_SHIFT(PAGE_SHIFT)) u_slot (
      .bp_addr_i  (bp_addr_i[i*AW +: AW]),
      .typ_i      (ctrl_i[16 + 4*i +: 2]),
      .len_code_i (ctrl_i[18 + 4*i +: 2]),
      .en_bits_i  (ctrl_i[2*i +: 2]),
      .acc_addr_i (acc_addr_i),
      .acc_size_i (acc_size_i),
      .acc_write_i(acc_write_i),
      .rel_en_o   (rel_en[i]),
      .page_en_o  (page_en[i]),
      .match_o    (match[i])
    );
  end

  assign active = !resume_i && (|rel_en);

  dbp_combine #(.NUM_SLOTS(NUM_SLOTS)) u_combine (
    .active_i    (active),
    .vendor_all_i(vendor_all_i),
    .sys_i       (acc_sys_i),
    .page_en_i   (page_en),
    .match_i     (match),
    .result_o    (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o       <= '0;
      result_valid_o <= 1'b0;
    end else begin
      result_valid_o <= acc_valid_i;
      if (acc_valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/dbp_range_match_chk.sv
module dbp_range_match_chk #(
  parameter int NUM_SLOTS = 4,
  localparam int RES_W    = NUM_SLOTS + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_sys_i,
  input logic             resume_i,
  input logic             vendor_all_i,
  input logic [RES_W-1:0] result_o,
  input logic             result_valid_o
);
  localparam int SIL = NUM_SLOTS + 1;

  assert_valid_follows_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> result_valid_o);
  assert_no_valid_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !result_valid_o);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> $stable(result_o));
  assert_resume_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && resume_i |=> result_o == '0);
  assert_silent_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> !(result_o[SIL] && (|result_o[NUM_SLOTS:1])));
  assert_nonsys_no_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_sys_i |=> !result_o[SIL]);
  assert_strict_no_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !vendor_all_i |=> !result_o[SIL]);
  assert_hit_has_page_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o && ((|result_o[NUM_SLOTS:1]) || result_o[SIL]) |-> result_o[0]);
endmodule

bind dbp_range_match dbp_range_match_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .acc_valid_i   (acc_valid_i),
  .acc_sys_i     (acc_sys_i),
  .resume_i      (resume_i),
  .vendor_all_i  (vendor_all_i),
  .result_o      (result_o),
  .result_valid_o(result_valid_o)
);

// File: tb/dbp_range_match_test.sv
`timescale 1ns/1ps
module dbp_range_match_test;
  logic        clk_i = 0, rst_ni = 0;
  logic        acc_valid_i = 0, acc_write_i = 0, acc_sys_i = 0, resume_i = 0, vendor_all_i = 0;
  logic [31:0] acc_addr_i = '0;
  logic [3:0]  acc_size_i = 4'd1;
  logic [31:0] ctrl_i = '0;
  logic [127:0] bp_addr_i = '0;
  logic [5:0]  result_o;
  logic        result_valid_o;

  int checks = 0, errors = 0;
  logic [31:0] bp [4];

  always #4 clk_i = ~clk_i;

  dbp_range_match uut (.*);

  function automatic int lenb(input logic [1:0] c);
    case (c) 2'b00: return 1; 2'b01: return 2; 2'b10: return 8; default: return 4; endcase
  endfunction

  function automatic logic [5:0] model(input logic [31:0] a, input int sz, input logic wr,
      input logic sy, input logic rf, input logic va, input logic [31:0] c);
    logic [3:0] en = 0, mt = 0, relv = 0;
    logic [5:0] r = 0;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] t = c[16+4*i +: 2];
      logic ok = wr ? t[0] : (t == 2'b11);
      logic e = c[2*i] | c[2*i+1];
      longint lo = bp[i], ah = longint'(a) + sz;
      if (ok && e) relv[i] = 1;
      if (ok && (bp[i][31:12] == a[31:12])) begin
        if (e) en[i] = 1;
        if ((longint'(a) < lo + lenb(c[18+4*i +: 2])) && (ah > lo)) mt[i] = 1;
      end
    end
    if (rf || relv == 0) return 0;
    r[0] = |en;
    if ((en & mt) != 0) begin
      if (!va) r[4:1] = en & mt;
      else if (!sy) r[4:1] = mt;
      else r[5] = 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic [1:0] t0, l0, e0, t1, l1, e1,
                                          t2, l2, e2, t3, l3, e3);
    logic [31:0] c = 0;
    c[1:0] = e0; c[3:2] = e1; c[5:4] = e2; c[7:6] = e3;
    c[17:16] = t0; c[19:18] = l0; c[21:20] = t1; c[23:22] = l1;
    c[25:24] = t2; c[27:26] = l2; c[29:28] = t3; c[31:30] = l3;
    return c;
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load_bp();
    bp_addr_i = {bp[3], bp[2], bp[1], bp[0]};
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic access(input string req, input logic [31:0] a, input int sz, input logic wr,
                        input logic sy);
    logic [5:0] exp;
    @(negedge clk_i);
    acc_addr_i = a; acc_size_i = 4'(sz); acc_write_i = wr; acc_sys_i = sy; acc_valid_i = 1;
    exp = model(a, sz, wr, sy, resume_i, vendor_all_i, ctrl_i);
    @(negedge clk_i);
    acc_valid_i = 0;
    check({req, " valid"}, {5'd0, result_valid_o}, 6'd1);
    check(req, result_o, exp);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] held;
    void'($urandom(32'd1234));
    bp = '{32'h0, 32'h0, 32'h0, 32'h0};
    #20;
    check("R12 reset result", result_o, 6'd0);
    check("R12 reset valid", {5'd0, result_valid_o}, 6'd0);
    @(negedge clk_i); rst_ni = 1;

    // R1 + R4: each length code, boundaries
    bp[0] = 32'h1000_0100; load_bp();
    for (int c = 0; c < 4; c++) begin
      ctrl_i = mk_ctrl(2'b01, 2'(c), 2'b01, 0,0,0, 0,0,0, 0,0,0);
      access("R1 last byte hit", bp[0] + lenb(2'(c)) - 1, 1, 1, 0);
      check("R1 last byte literal", result_o, 6'b000011);
      access("R1 past end miss", bp[0] + lenb(2'(c)), 1, 1, 0);
      check("R1 past end literal", result_o, 6'b000001);
    end
    ctrl_i = mk_ctrl(2'b01, 2'b00, 2'b10, 0,0,0, 0,0,0, 0,0,0);
    access("R4 below miss", bp[0] - 2, 2, 1, 0);
    access("R4 below overlap", bp[0] - 2, 3, 1, 0);
    check("R4 overlap literal", result_o, 6'b000011);

    // R2 / R3 type filtering
    ctrl_i = mk_ctrl(2'b01, 2'b00, 2'b01, 0,0,0, 0,0,0, 0,0,0);
    access("R2 read vs write-only", bp[0], 1, 0, 0);
    check("R2 read ignores type01", result_o, 6'd0);
    ctrl_i = mk_ctrl(2'b11, 2'b00, 2'b01, 0,0,0, 0,0,0, 0,0,0);
    access("R2 read vs rw", bp[0], 1, 0, 0);
    access("R3 write vs rw", bp[0], 1, 1, 0);
    ctrl_i = mk_ctrl(2'b00, 2'b00, 2'b01, 0,0,0, 0,0,0, 0,0,0);
    access("R3 write vs exec", bp[0], 1, 1, 0);
    check("R3 exec ignored", result_o, 6'd0);
    ctrl_i = mk_ctrl(2'b10, 2'b00, 2'b01, 0,0,0, 0,0,0, 0,0,0);
    access("R3 write vs io", bp[0], 1, 1, 0);

    // R5 page
    ctrl_i = mk_ctrl(2'b11, 2'b11, 2'b01, 0,0,0, 0,0,0, 0,0,0);
    access("R5 other page", bp[0] + 32'h1000, 4, 1, 0);
    check("R5 other page literal", result_o, 6'd0);
    access("R5 same page no overlap", bp[0] + 32'h40, 4, 1, 0);
    check("R5 page bit literal", result_o, 6'b000001);

    // R6 resume
    resume_i = 1;
    access("R6 resume", bp[0], 4, 1, 0);
    resume_i = 0;

    // R7/R8/R9/R10/R11 two slots overlapping, slot1 disabled
    bp[1] = bp[0]; load_bp();
    ctrl_i = mk_ctrl(2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 0,0,0, 0,0,0);
    vendor_all_i = 1;
    access("R7 none enabled", bp[0], 4, 1, 0);
    check("R7 literal", result_o, 6'd0);
    ctrl_i = mk_ctrl(2'b11, 2'b11, 2'b10, 2'b11, 2'b11, 2'b00, 0,0,0, 0,0,0);
    access("R10 all matched", bp[0], 4, 1, 0);
    check("R10 literal", result_o, 6'b000111);
    access("R11 sys silent", bp[0], 4, 1, 1);
    check("R11 literal", result_o, 6'b100001);
    access("R8 enabled no overlap", bp[0] + 8, 4, 1, 0);
    vendor_all_i = 0;
    access("R9 strict enabled only", bp[0], 4, 1, 0);
    check("R9 literal", result_o, 6'b000011);
    access("R9 strict sys normal", bp[0], 4, 1, 1);
    check("R9 sys literal", result_o, 6'b000011);

    // R12 hold
    held = result_o;
    @(negedge clk_i);
    acc_addr_i = 32'hFFFF_0000;
    @(negedge clk_i);
    check("R12 hold result", result_o, held);
    check("R12 valid low", {5'd0, result_valid_o}, 6'd0);

    // random
    for (int n = 0; n < 600; n++) begin
      logic [31:0] base = 32'h0004_2000;
      for (int i = 0; i < 4; i++)
        bp[i] = (($urandom % 8) == 0) ? base + 32'h1000 + ($urandom % 64)
                                      : base + ($urandom % 64);
      load_bp();
      ctrl_i = $urandom;
      resume_i = (($urandom % 16) == 0);
      vendor_all_i = $urandom % 2;
      access("R4 R10 random", base + ($urandom % 72), 1 + ($urandom % 8),
             $urandom % 2, $urandom % 2);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule